// File: doc/BRIEF.md
# Command-Driven I2C Byte Master

This block is a single-master-channel I2C engine that moves one byte at a time under discrete commands from its host logic. Six commands are available: open the bus with a START, issue a repeated START, shift out a byte (a slave address with its direction bit, or a data byte), clock in a byte from a slave, drive the acknowledge bit after a received byte, and close the bus with a STOP. The host issues one command, waits for the completion pulse, then issues the next. The engine never queues work. A byte write that arrives while an operation is running raises a write-collision pulse and is thrown away.

SCL timing comes from a countdown timer with a reload input. Every SCL half-period is (reload+1) system clocks, and the timer runs only while an operation is in progress. After each operation the engine holds both lines at the levels the operation left them at. SDA changes only while SCL is low, except for the deliberate edges of START and STOP. On an address byte the host places the 7-bit slave address in the upper bits and the direction bit in bit 0 (0 = master writes, 1 = master reads). The engine sends whatever byte it is given.

For multi-master use, the engine reads SDA back whenever it has released the line in order to signal a 1. If it reads a low level there, it has lost arbitration: it pulses a bus-collision flag, releases both lines, abandons the operation and returns to idle. The line outputs are active-high pull-down enables for open-drain pads. Clock stretching and slave mode are not supported.

Top module: `i2c_cmd_master`

## Requirements
- R1: During and after reset, with no command issued, sda_oe and scl_oe are 0, done, wcol and bcol are 0, and ack_rx is 1.
- R2: A START from a released bus releases both lines for one half-period, pulls SDA low with SCL high for one half-period, then pulls SCL low for one half-period. done pulses 3 half-periods after the command is accepted, and SDA and SCL then stay pulled low until the next command.
- R3: One half-period lasts reload+1 clock cycles (reload at least 1), so every operation's length in cycles scales with reload+1.
- R4: A byte write drives 8 bits, MSB first, one per SCL pulse, with SDA changing only while SCL is low. SDA is released for a ninth pulse, and done pulses 18 half-periods after acceptance with SCL left pulled low.
- R5: ack_rx takes the SDA level sampled during the ninth pulse of a byte write (0 = slave acknowledged) and changes only in the cycle where done is high.
- R6: A receive command gives 8 SCL pulses with SDA released, shifts the sampled bits MSB first into rx_data, and pulses done 16 half-periods after acceptance.
- R7: An acknowledge command gives one SCL pulse with SDA pulled low when ack_nack is 0 and released when ack_nack is 1. done pulses 2 half-periods after acceptance.
- R8: A STOP pulls SDA low, releases SCL one half-period later, then releases SDA one half-period after that, so SDA rises while SCL is high. done pulses 3 half-periods after acceptance with both lines released.
- R9: A repeated START first releases SDA with SCL still low for one half-period, then runs the START sequence. done pulses 4 half-periods after acceptance and a START condition appears on the bus.
- R10: wr_en while an operation is running pulses wcol the next cycle. The byte is discarded: no SCL pulse follows once the running operation ends.
- R11: If SDA reads low at the end of an SCL-high half-period in which the engine released SDA to send a 1 (data bit of a write, or a not-acknowledge), or at the end of the first half-period of a START, bcol pulses, done does not pulse, and both lines are released in the same cycle.
- R12: If SDA is still low at the end of the last half-period of a STOP, bcol pulses instead of done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reload | input | RELOAD_W | Half-period reload value; a half-period is reload+1 clocks |
| cmd_start | input | 1 | Begin a START condition (highest priority) |
| cmd_restart | input | 1 | Begin a repeated START |
| cmd_stop | input | 1 | Begin a STOP condition |
| wr_en | input | 1 | Transmit wr_data as one byte and sample the acknowledge |
| wr_data | input | DATA_W | Byte to transmit, MSB first |
| cmd_recv | input | 1 | Clock in one byte from the slave |
| cmd_ack | input | 1 | Drive the acknowledge bit after a received byte |
| ack_nack | input | 1 | Acknowledge value: 0 pulls SDA low, 1 releases it |
| sda_in | input | 1 | Level read from the SDA line |
| sda_oe | output | 1 | 1 pulls SDA low |
| scl_oe | output | 1 | 1 pulls SCL low |
| rx_data | output | DATA_W | Last received byte |
| done | output | 1 | One-cycle pulse when an operation completes |
| ack_rx | output | 1 | SDA level seen during the ninth pulse of the last write |
| wcol | output | 1 | One-cycle pulse: byte write refused while busy |
| bcol | output | 1 | One-cycle pulse: arbitration lost, operation abandoned |

## Verification
The checker assumes that the host issues at most one command per cycle and only while the engine is idle, except for the deliberate late write in the write-collision case. It also assumes that reload is at least 1 and does not change during an operation, and that sda_in is already synchronous to clk when no input synchronizer stages are configured. The bench meets these assumptions. It pulses each command for exactly one cycle after the previous operation has ended, and it changes reload only between operations. It models the bus as a wired-AND of the engine's enables, a slave that follows a per-operation bit pattern advancing on each SCL fall, and an extra pull-down standing in for a rival master. All of these are combinational, so sda_in is synchronous by construction.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_RS_LOW,
      ST_ST_REL,
      ST_ST_SDA,
      ST_ST_SCL,
      ST_BIT_LO,
      ST_BIT_HI,
      ST_SP_LO,
      ST_SP_HI,
      ST_SP_END
   } eng_state_t;

   typedef enum logic [1:0] {
      OP_TX,
      OP_RX,
      OP_ACK
   } byte_op_t;

endpackage

// File: rtl/i2c_half_timer.sv
module i2c_half_timer #(
   parameter int RW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic [RW-1:0] reload,
   output logic          tick
);

   logic [RW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!run || cnt == '0)
         cnt <= reload;
      else
         cnt <= cnt - 1'b1;
   end

   assign tick = run && (cnt == '0);

endmodule

// File: rtl/i2c_byte_shreg.sv
module i2c_byte_shreg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] din,
   input  logic         shift,
   input  logic         bit_in,
   output logic [W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= '0;
      else if (load)
         q <= din;
      else if (shift)
         q <= {q[W-2:0], bit_in};
   end

endmodule

// File: rtl/i2c_sda_sync.sv
module i2c_sda_sync #(
   parameter int STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES == 0) begin : g_bypass
         logic unused_clk_rst;
         assign unused_clk_rst = clk ^ rst_n;
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               r <= '1;
            end else begin
               r[0] <= d;
               for (int i = 1; i < STAGES; i++) r[i] <= r[i-1];
            end
         end
         assign q = r[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
   import i2c_cmd_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int RELOAD_W    = 7,
   parameter int SYNC_STAGES = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [RELOAD_W-1:0] reload,
   input  logic                cmd_start,
   input  logic                cmd_restart,
   input  logic                cmd_stop,
   input  logic                wr_en,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic                cmd_recv,
   input  logic                cmd_ack,
   input  logic                ack_nack,
   input  logic                sda_in,
   output logic                sda_oe,
   output logic                scl_oe,
   output logic [DATA_W-1:0]   rx_data,
   output logic                done,
   output logic                ack_rx,
   output logic                wcol,
   output logic                bcol
);

   localparam int CNT_W = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] LAST_TX = CNT_W'(DATA_W);
   localparam logic [CNT_W-1:0] LAST_RX = CNT_W'(DATA_W - 1);

   if (DATA_W < 2) begin : g_bad_data_w
      $error("DATA_W must be at least 2");
   end
   if (RELOAD_W < 1) begin : g_bad_reload_w
      $error("RELOAD_W must be at least 1");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
      $error("SYNC_STAGES must be 0 to 3");
   end

   eng_state_t       state;
   byte_op_t         op;
   logic [CNT_W-1:0] bitcnt;
   logic             ack_hold;
   logic             half_tick;
   logic             sda_s;
   logic [DATA_W-1:0] sh_q;
   logic             idle;
   logic             last_bit, drv_rel, chk_bit;
   logic             sh_load, sh_shift;

   assign idle = (state == ST_IDLE);

   i2c_sda_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s)
   );

   i2c_half_timer #(.RW(RELOAD_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .run(!idle), .reload(reload), .tick(half_tick)
   );

   assign sh_load  = idle && wr_en && !cmd_start && !cmd_restart && !cmd_stop;
   assign sh_shift = (state == ST_BIT_HI) && half_tick && (op != OP_ACK)
                     && !(op == OP_TX && bitcnt == LAST_TX);

   i2c_byte_shreg #(.W(DATA_W)) u_shreg (
      .clk(clk), .rst_n(rst_n), .load(sh_load), .din(wr_data),
      .shift(sh_shift), .bit_in(sda_s), .q(sh_q)
   );

   assign rx_data = sh_q;

   // Per-bit properties of the current byte slot.
   always_comb begin
      last_bit = 1'b1;
      drv_rel  = 1'b1;
      chk_bit  = 1'b0;
      case (op)
         OP_TX: begin
            last_bit = (bitcnt == LAST_TX);
            drv_rel  = (bitcnt == LAST_TX) ? 1'b1 : sh_q[DATA_W-1];
            chk_bit  = (bitcnt != LAST_TX);
         end
         OP_RX: begin
            last_bit = (bitcnt == LAST_RX);
         end
         default: begin
            drv_rel = ack_hold;
            chk_bit = 1'b1;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         op       <= OP_TX;
         bitcnt   <= '0;
         ack_hold <= 1'b1;
         sda_oe   <= 1'b0;
         scl_oe   <= 1'b0;
         ack_rx   <= 1'b1;
         done     <= 1'b0;
         wcol     <= 1'b0;
         bcol     <= 1'b0;
      end else begin
         done <= 1'b0;
         bcol <= 1'b0;
         wcol <= wr_en && !idle;
         case (state)
            ST_IDLE: begin
               bitcnt <= '0;
               if (cmd_start) begin
                  sda_oe <= 1'b0;
                  scl_oe <= 1'b0;
                  state  <= ST_ST_REL;
               end else if (cmd_restart) begin
                  sda_oe <= 1'b0;
                  state  <= ST_RS_LOW;
               end else if (cmd_stop) begin
                  sda_oe <= 1'b1;
                  state  <= ST_SP_LO;
               end else if (wr_en) begin
                  op    <= OP_TX;
                  state <= ST_BIT_LO;
               end else if (cmd_recv) begin
                  op    <= OP_RX;
                  state <= ST_BIT_LO;
               end else if (cmd_ack) begin
                  op       <= OP_ACK;
                  ack_hold <= ack_nack;
                  state    <= ST_BIT_LO;
               end
            end
            ST_RS_LOW: if (half_tick) begin
               scl_oe <= 1'b0;
               state  <= ST_ST_REL;
            end
            ST_ST_REL: if (half_tick) begin
               if (!sda_s) begin
                  bcol   <= 1'b1;
                  sda_oe <= 1'b0;
                  scl_oe <= 1'b0;
                  state  <= ST_IDLE;
               end else begin
                  sda_oe <= 1'b1;
                  state  <= ST_ST_SDA;
               end
            end
            ST_ST_SDA: if (half_tick) begin
               scl_oe <= 1'b1;
               state  <= ST_ST_SCL;
            end
            ST_ST_SCL: if (half_tick) begin
               done  <= 1'b1;
               state <= ST_IDLE;
            end
            ST_BIT_LO: begin
               sda_oe <= !drv_rel;
               if (half_tick) begin
                  scl_oe <= 1'b0;
                  state  <= ST_BIT_HI;
               end
            end
            ST_BIT_HI: if (half_tick) begin
               if (chk_bit && drv_rel && !sda_s) begin
                  bcol   <= 1'b1;
                  sda_oe <= 1'b0;
                  scl_oe <= 1'b0;
                  state  <= ST_IDLE;
               end else begin
                  scl_oe <= 1'b1;
                  if (op == OP_TX && last_bit) ack_rx <= sda_s;
                  if (last_bit) begin
                     done  <= 1'b1;
                     state <= ST_IDLE;
                  end else begin
                     bitcnt <= bitcnt + 1'b1;
                     state  <= ST_BIT_LO;
                  end
               end
            end
            ST_SP_LO: if (half_tick) begin
               scl_oe <= 1'b0;
               state  <= ST_SP_HI;
            end
            ST_SP_HI: if (half_tick) begin
               sda_oe <= 1'b0;
               state  <= ST_SP_END;
            end
            ST_SP_END: if (half_tick) begin
               if (!sda_s) bcol <= 1'b1;
               else        done <= 1'b1;
               state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/i2c_cmd_master_chk.sv
module i2c_cmd_master_chk
   import i2c_cmd_pkg::*;
#(
   parameter int RW = 7
) (
   input logic          clk,
   input logic          rst_n,
   input eng_state_t    state,
   input logic          tick,
   input logic [RW-1:0] reload,
   input logic          sda_oe,
   input logic          scl_oe,
   input logic          done,
   input logic          bcol,
   input logic          wcol,
   input logic          wr_en,
   input logic          ack_rx
);

   // R11
   bcol_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bcol |-> (!sda_oe && !scl_oe));

   // R11
   flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && bcol));

   // R5
   ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(ack_rx));

   // R10
   wcol_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wcol |-> $past(wr_en));

   // R4
   sda_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_BIT_HI && $past(state) == ST_BIT_HI) |-> $stable(sda_oe));

   // R2
   scl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && $past(state) == ST_IDLE) |-> $stable(scl_oe));

   // R3
   tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && reload != '0 && $stable(reload)) |=> !tick);

endmodule

bind i2c_cmd_master i2c_cmd_master_chk #(.RW(RELOAD_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .state(state), .tick(half_tick),
   .reload(reload), .sda_oe(sda_oe), .scl_oe(scl_oe), .done(done),
   .bcol(bcol), .wcol(wcol), .wr_en(wr_en), .ack_rx(ack_rx)
);

// File: tb/i2c_cmd_master_tb.sv
`timescale 1ns/1ps
module i2c_cmd_master_tb;

   localparam int K_START = 0, K_RESTART = 1, K_STOP = 2, K_WR = 3, K_RECV = 4, K_ACK = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [6:0] reload = 7'd3;
   logic cmd_start = 0, cmd_restart = 0, cmd_stop = 0, wr_en = 0, cmd_recv = 0, cmd_ack = 0;
   logic ack_nack = 0;
   logic [7:0] wr_data = '0;
   logic sda_oe, scl_oe, done, ack_rx, wcol, bcol;
   logic [7:0] rx_data;

   logic [8:0] slv_pat = 9'h1FF;
   logic slv_arm = 0, mon_clr = 0, ext_low = 0;
   int slv_idx = 0;
   logic slv_sda, sda_line, scl_line, scl_q = 1'b1, sda_q = 1'b1;
   logic [8:0] mon_sh = '0;
   int mon_cnt = 0, starts = 0, stops = 0, wcol_cnt = 0;

   int checks = 0, errors = 0, cyc = 0;
   int n_cyc;
   logic got_done, got_bcol;

   always #2.5 clk = ~clk;

   assign slv_sda  = (slv_idx < 9) ? slv_pat[8 - slv_idx] : 1'b1;
   assign sda_line = !sda_oe && slv_sda && !ext_low;
   assign scl_line = !scl_oe;

   i2c_cmd_master u_dut (
      .clk(clk), .rst_n(rst_n), .reload(reload), .cmd_start(cmd_start),
      .cmd_restart(cmd_restart), .cmd_stop(cmd_stop), .wr_en(wr_en),
      .wr_data(wr_data), .cmd_recv(cmd_recv), .cmd_ack(cmd_ack),
      .ack_nack(ack_nack), .sda_in(sda_line), .sda_oe(sda_oe), .scl_oe(scl_oe),
      .rx_data(rx_data), .done(done), .ack_rx(ack_rx), .wcol(wcol), .bcol(bcol)
   );

   // Bus monitor and slave bit pointer
   always @(posedge clk) begin
      scl_q <= scl_line;
      sda_q <= sda_line;
      if (slv_arm) slv_idx <= 0;
      else if (scl_q && !scl_line) slv_idx <= slv_idx + 1;
      if (mon_clr) begin
         mon_cnt <= 0; starts <= 0; stops <= 0; wcol_cnt <= 0; mon_sh <= '0;
      end else begin
         if (!scl_q && scl_line) begin
            mon_sh  <= {mon_sh[7:0], sda_line};
            mon_cnt <= mon_cnt + 1;
         end
         if (scl_q && scl_line && sda_q && !sda_line) starts <= starts + 1;
         if (scl_q && scl_line && !sda_q && sda_line) stops <= stops + 1;
         if (wcol) wcol_cnt <= wcol_cnt + 1;
      end
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         checks++; errors++;
         $display("FAIL watchdog (all requirements) actual=%0d expected<150000", cyc);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic run_op(input int kind, input logic [7:0] d, input logic nk,
                         input logic [8:0] pat, input int late_wr);
      @(negedge clk);
      mon_clr = 1; slv_arm = 1; slv_pat = pat;
      case (kind)
         K_START:   cmd_start = 1;
         K_RESTART: cmd_restart = 1;
         K_STOP:    cmd_stop = 1;
         K_WR:      begin wr_data = d; wr_en = 1; end
         K_RECV:    cmd_recv = 1;
         default:   begin ack_nack = nk; cmd_ack = 1; end
      endcase
      n_cyc = 0; got_done = 0; got_bcol = 0;
      while (!got_done && !got_bcol && n_cyc < 4000) begin
         @(posedge clk);
         n_cyc++;
         @(negedge clk);
         cmd_start = 0; cmd_restart = 0; cmd_stop = 0; wr_en = 0;
         cmd_recv = 0; cmd_ack = 0; mon_clr = 0; slv_arm = 0;
         if (late_wr != 0 && n_cyc == late_wr) wr_en = 1;
         if (done) got_done = 1;
         if (bcol) got_bcol = 1;
      end
      @(negedge clk);
   endtask

   task automatic t_reset();
      check("R1 sda_oe", int'(sda_oe), 0);
      check("R1 scl_oe", int'(scl_oe), 0);
      check("R1 flags", int'({done, wcol, bcol}), 0);
      check("R1 ack_rx", int'(ack_rx), 1);
   endtask

   task automatic t_write_path();
      int h;
      h = int'(reload) + 1;
      run_op(K_START, 8'h00, 0, 9'h1FF, 0);
      check("R2 start done", int'(got_done), 1);
      check("R2 start cycles", n_cyc, 3*h + 1);
      check("R2 start seen", starts, 1);
      repeat (8) @(negedge clk);
      check("R2 lines held low", int'({sda_oe, scl_oe}), 3);
      run_op(K_WR, 8'hA0, 0, 9'b111111110, 0);
      check("R4 write cycles", n_cyc, 18*h + 1);
      check("R4 pulses", mon_cnt, 9);
      check("R4 wire byte", int'(mon_sh[8:1]), 8'hA0);
      check("R5 ack seen", int'(ack_rx), 0);
      check("R4 scl held", int'(scl_oe), 1);
      run_op(K_WR, 8'h3C, 0, 9'h1FF, 0);
      check("R4 wire byte 2", int'(mon_sh[8:1]), 8'h3C);
      check("R5 nack seen", int'(ack_rx), 1);
      check("R4 sda released", int'(sda_oe), 0);
   endtask

   task automatic t_read_path();
      int h;
      h = int'(reload) + 1;
      run_op(K_RESTART, 8'h00, 0, 9'h1FF, 0);
      check("R9 restart cycles", n_cyc, 4*h + 1);
      check("R9 start seen", starts, 1);
      run_op(K_WR, 8'hA1, 0, 9'b111111110, 0);
      check("R5 addr ack", int'(ack_rx), 0);
      run_op(K_RECV, 8'h00, 0, {8'h96, 1'b1}, 0);
      check("R6 recv cycles", n_cyc, 16*h + 1);
      check("R6 recv data", int'(rx_data), 8'h96);
      check("R6 pulses", mon_cnt, 8);
      run_op(K_ACK, 8'h00, 0, 9'h1FF, 0);
      check("R7 ack cycles", n_cyc, 2*h + 1);
      check("R7 ack low", int'(mon_sh[0]), 0);
      check("R7 ack pulses", mon_cnt, 1);
      run_op(K_RECV, 8'h00, 0, {8'h5B, 1'b1}, 0);
      check("R6 recv data 2", int'(rx_data), 8'h5B);
      run_op(K_ACK, 8'h00, 1, 9'h1FF, 0);
      check("R7 nack high", int'(mon_sh[0]), 1);
      run_op(K_STOP, 8'h00, 0, 9'h1FF, 0);
      check("R8 stop cycles", n_cyc, 3*h + 1);
      check("R8 stop seen", stops, 1);
      check("R8 released", int'({sda_oe, scl_oe}), 0);
   endtask

   task automatic t_wcol();
      run_op(K_START, 8'h00, 0, 9'h1FF, 2);
      check("R10 start still done", int'(got_done), 1);
      repeat (20) @(negedge clk);
      check("R10 wcol pulses", wcol_cnt, 1);
      check("R10 no pulses after", mon_cnt, 0);
      check("R10 scl held", int'(scl_oe), 1);
      run_op(K_STOP, 8'h00, 0, 9'h1FF, 0);
   endtask

   task automatic t_arb();
      int h;
      h = int'(reload) + 1;
      run_op(K_START, 8'h00, 0, 9'h1FF, 0);
      run_op(K_WR, 8'hFF, 0, 9'b101111111, 0);
      check("R11 tx bcol", int'(got_bcol), 1);
      check("R11 tx no done", int'(got_done), 0);
      check("R11 tx cycles", n_cyc, 4*h + 1);
      check("R11 tx released", int'({sda_oe, scl_oe}), 0);
      ext_low = 1;
      run_op(K_START, 8'h00, 0, 9'h1FF, 0);
      check("R11 start bcol", int'(got_bcol), 1);
      check("R11 start cycles", n_cyc, h + 1);
      ext_low = 0;
      repeat (4) @(negedge clk);
      run_op(K_START, 8'h00, 0, 9'h1FF, 0);
      ext_low = 1;
      run_op(K_STOP, 8'h00, 0, 9'h1FF, 0);
      check("R12 stop bcol", int'(got_bcol), 1);
      check("R12 stop cycles", n_cyc, 3*h + 1);
      check("R12 no stop seen", stops, 0);
      ext_low = 0;
      repeat (4) @(negedge clk);
   endtask

   task automatic t_baud();
      reload = 7'd1;
      run_op(K_START, 8'h00, 0, 9'h1FF, 0);
      check("R3 start h2", n_cyc, 7);
      run_op(K_WR, 8'h55, 0, 9'b111111110, 0);
      check("R3 write h2", n_cyc, 37);
      check("R3 byte h2", int'(mon_sh[8:1]), 8'h55);
      run_op(K_STOP, 8'h00, 0, 9'h1FF, 0);
      check("R3 stop h2", n_cyc, 7);
      reload = 7'd6;
      run_op(K_START, 8'h00, 0, 9'h1FF, 0);
      check("R3 start h7", n_cyc, 22);
      run_op(K_STOP, 8'h00, 0, 9'h1FF, 0);
      check("R3 stop h7", n_cyc, 22);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      t_reset();
      t_write_path();
      t_read_path();
      t_wcol();
      t_arb();
      t_baud();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule